// File: doc/BRIEF.md
# Byte-Lane Parity Generator/Checker

This block guards a 36-bit data path made of four 9-bit lanes, where the top bit of every lane carries that lane's parity. On the inbound side it tests each lane of the incoming bus against the selected sense, odd or even. It drives an active-low error flag when a lane that the current bus width actually uses is wrong. On the outbound side it can rebuild the parity bit of every lane of the data being read out, so the receiver always sees correct parity.

There is only one parity tree. While a read with generation is under way, the tree works on the outgoing data. During that time the inbound check cannot run, and the error flag is held inactive. The bus-width and endian selection is sampled on each clock edge and applied one edge later. The lane mask therefore always matches the width that the surrounding port logic is using.

Top module: `lane_parity_unit`

## Requirements
- R1: The bus is split into four lanes at bits 8:0, 17:9, 26:18 and 35:27. Bit 8 of each lane (bus bits 8, 17, 26, 35) is that lane's parity bit.
- R2: With `odd_sel` = 1 a lane is correct when its 9 bits hold an odd number of ones. With `odd_sel` = 0 it is correct when they hold an even number of ones. The same sense is used for generation.
- R3: Outside a generated read, `err_n` is low in the same cycle, with no clock edge in between, exactly when at least one valid lane of `chk_bus` is incorrect.
- R4: Valid lanes follow the active width code. 2'b00 (long word) and 2'b11 (full-width register access) enable all four lanes. 2'b01 (word) enables lanes 3 and 2 when `big_end` = 1, and lanes 1 and 0 when `big_end` = 0. 2'b10 (byte) enables lane 3 when `big_end` = 1, and lane 0 when `big_end` = 0. Errors in other lanes are ignored.
- R5: `size_sel` and `big_end` are captured on every rising edge and become active on the following rising edge. A change therefore alters the mask from the second rising edge after it is applied. Reset makes the active setting long word, little endian.
- R6: While `rd_active` and `gen_en` are both high, every lane of `data_out` carries the data bits of `src_data`, and its parity bit is set so that the lane meets the sense chosen by `odd_sel`.
- R7: While `rd_active` or `gen_en` is low, `data_out` equals `src_data` bit for bit, parity bits included.
- R8: While `rd_active` and `gen_en` are both high, `err_n` is high whatever `chk_bus` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the width setting |
| chk_bus | input | 36 | Incoming bus under check |
| src_data | input | 36 | Data about to be driven out |
| rd_active | input | 1 | A read is driving `data_out` |
| gen_en | input | 1 | Parity generation enabled on reads |
| odd_sel | input | 1 | 1 = odd parity, 0 = even parity |
| size_sel | input | 2 | Width code: 00 long, 01 word, 10 byte, 11 register access |
| big_end | input | 1 | 1 = narrow widths use the upper lanes |
| data_out | output | 36 | Outgoing data, parity regenerated when enabled |
| err_n | output | 1 | Active-low parity error on valid lanes |

## Verification
Checking and generation compete for the single tree. They collide when a generated read is in progress while `chk_bus` carries lanes with broken parity. The bench provokes this by driving deliberately bad inbound lanes together with a generated read under both parity senses. It expects `err_n` to stay high while every lane of `data_out` satisfies the selected sense. A second overlap is a width change that meets a check in the same cycle: the bench probes the mask on the cycles just before and just after the change becomes active, using errors placed in lanes that only one of the two widths covers.

// File: rtl/lpu_pkg.sv
package lpu_pkg;

    typedef enum logic [1:0] {
        SZ_LONG = 2'b00,
        SZ_WORD = 2'b01,
        SZ_BYTE = 2'b10,
        SZ_REG  = 2'b11
    } bus_size_e;

    typedef struct packed {
        bus_size_e size;
        logic      big_end;
    } lane_cfg_t;

    typedef struct packed {
        lane_cfg_t staged;
        lane_cfg_t active;
    } cfg_state_t;

    localparam lane_cfg_t CFG_RESET = '{size: SZ_LONG, big_end: 1'b0};

endpackage

// File: rtl/lpu_lane_mask.sv
module lpu_lane_mask
    import lpu_pkg::*;
#(
    parameter int LANES = 4
) (
    input  lane_cfg_t         cfg,
    output logic [LANES-1:0]  valid
);
    localparam int HALF = (LANES > 1) ? LANES / 2 : 1;

    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            unique case (cfg.size)
                SZ_WORD: valid[i] = cfg.big_end ? (i >= LANES - HALF) : (i < HALF);
                SZ_BYTE: valid[i] = cfg.big_end ? (i == LANES - 1) : (i == 0);
                default: valid[i] = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/lpu_parity_tree.sv
module lpu_parity_tree #(
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic [LANES*LANE_W-1:0] word_in,
    input  logic                    odd_sel,
    output logic [LANES-1:0]        data_par,
    output logic [LANES-1:0]        lane_ok
);
    localparam int DATA_W = LANE_W - 1;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic par_bit;
        assign data_par[g] = ^word_in[g*LANE_W +: DATA_W];
        assign par_bit     = word_in[g*LANE_W + DATA_W];
        assign lane_ok[g]  = ((data_par[g] ^ par_bit) == odd_sel);
    end
endmodule

// File: rtl/lane_parity_unit.sv
module lane_parity_unit
    import lpu_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [LANES*LANE_W-1:0] chk_bus,
    input  logic [LANES*LANE_W-1:0] src_data,
    input  logic                    rd_active,
    input  logic                    gen_en,
    input  logic                    odd_sel,
    input  logic [1:0]              size_sel,
    input  logic                    big_end,
    output logic [LANES*LANE_W-1:0] data_out,
    output logic                    err_n
);
    localparam int BUS_W  = LANES * LANE_W;
    localparam int DATA_W = LANE_W - 1;

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d              = st_q;
        st_d.staged.size    = bus_size_e'(size_sel);
        st_d.staged.big_end = big_end;
        st_d.active         = st_q.staged;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{staged: CFG_RESET, active: CFG_RESET};
        end else begin
            st_q <= st_d;
        end
    end

    logic             gen_on;
    logic [BUS_W-1:0] tree_in;
    logic [LANES-1:0] data_par, lane_ok, valid;

    assign gen_on  = rd_active & gen_en;
    assign tree_in = gen_on ? src_data : chk_bus;

    lpu_parity_tree #(.LANES(LANES), .LANE_W(LANE_W)) u_tree (
        .word_in  (tree_in),
        .odd_sel  (odd_sel),
        .data_par (data_par),
        .lane_ok  (lane_ok)
    );

    lpu_lane_mask #(.LANES(LANES)) u_mask (
        .cfg   (st_q.active),
        .valid (valid)
    );

    assign err_n = gen_on | ~(|(~lane_ok & valid));

    for (genvar g = 0; g < LANES; g++) begin : g_out
        assign data_out[g*LANE_W +: DATA_W] = src_data[g*LANE_W +: DATA_W];
        assign data_out[g*LANE_W + DATA_W]  = gen_on ? (data_par[g] ^ odd_sel)
                                                     : src_data[g*LANE_W + DATA_W];
    end
endmodule

// File: rtl/lpu_checker.sv
module lpu_checker #(
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [LANES*LANE_W-1:0] chk_bus,
    input logic [LANES*LANE_W-1:0] src_data,
    input logic                    rd_active,
    input logic                    gen_en,
    input logic                    odd_sel,
    input logic [1:0]              size_sel,
    input logic                    big_end,
    input logic [LANES*LANE_W-1:0] data_out,
    input logic                    err_n
);
    localparam int DATA_W = LANE_W - 1;

    logic [LANES-1:0] bad;
    for (genvar g = 0; g < LANES; g++) begin : g_bad
        assign bad[g] = ((^chk_bus[g*LANE_W +: LANE_W]) != odd_sel);

        assert_gen_sense_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_active && gen_en) |-> ((^data_out[g*LANE_W +: LANE_W]) == odd_sel));

        assert_gen_keeps_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
            data_out[g*LANE_W +: DATA_W] == src_data[g*LANE_W +: DATA_W]);
    end

    assert_passthrough_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_active && gen_en) |-> (data_out == src_data));

    assert_flag_forced_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_active && gen_en) |-> err_n);

    assert_flag_needs_bad_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !err_n |-> (|bad));

    assert_long_all_lanes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(size_sel) == 2'b00 && $past(size_sel, 2) == 2'b00
         && !(rd_active && gen_en) && (|bad)) |-> !err_n);
endmodule

bind lane_parity_unit lpu_checker #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (.*);

// File: tb/lane_parity_unit_tb.sv
module lane_parity_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [35:0] chk_bus, src_data, data_out;
    logic        rd_active, gen_en, odd_sel, big_end, err_n;
    logic [1:0]  size_sel;

    always #2.5 clk = ~clk;

    lane_parity_unit u_dut (
        .clk(clk), .rst_n(rst_n), .chk_bus(chk_bus), .src_data(src_data),
        .rd_active(rd_active), .gen_en(gen_en), .odd_sel(odd_sel),
        .size_sel(size_sel), .big_end(big_end), .data_out(data_out), .err_n(err_n)
    );

    typedef struct {
        logic [35:0] data;
        logic        err;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    bit   done   = 0;

    // width history: [0] applied this step, [1] one step ago, [2] two steps ago
    logic [1:0] h_sz [3];
    logic       h_be [3];

    function automatic logic [3:0] want_mask(logic [1:0] sz, logic be);
        case (sz)
            2'b01:   return be ? 4'b1100 : 4'b0011;
            2'b10:   return be ? 4'b1000 : 4'b0001;
            default: return 4'b1111;
        endcase
    endfunction

    function automatic logic lane_good(logic [8:0] ln, logic odd);
        return (($countones(ln) % 2) == 1) == odd;
    endfunction

    task automatic step(input logic [35:0] chk, input logic [35:0] src, input logic rd,
                        input logic gen, input logic odd, input logic [1:0] sz,
                        input logic be, input string tag);
        exp_t       e;
        logic [3:0] m;
        logic       fail;
        @(posedge clk);
        #1;
        chk_bus = chk; src_data = src; rd_active = rd; gen_en = gen;
        odd_sel = odd; size_sel = sz; big_end = be;
        h_sz[2] = h_sz[1]; h_be[2] = h_be[1];
        h_sz[1] = h_sz[0]; h_be[1] = h_be[0];
        h_sz[0] = sz;      h_be[0] = be;
        m = want_mask(h_sz[2], h_be[2]);
        fail = 1'b0;
        e.data = src;
        for (int i = 0; i < 4; i++) begin
            if (m[i] && !lane_good(chk[i*9 +: 9], odd)) fail = 1'b1;
            if (rd && gen)
                e.data[i*9+8] = (($countones(src[i*9 +: 8]) % 2) == 1) ? ~odd : odd;
        end
        e.err = (rd && gen) ? 1'b1 : ~fail;
        e.tag = tag;
        q.push_back(e);
    endtask

    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_chk++;
            if (data_out !== e.data || err_n !== e.err) begin
                n_fail++;
                $display("FAIL %s: data_out=%h err_n=%b expected data_out=%h err_n=%b",
                         e.tag, data_out, err_n, e.data, e.err);
            end
        end
    end

    // lanes: G = good even, B = bad even (odd parity-good)
    localparam logic [8:0] GE = 9'h003;
    localparam logic [8:0] BE = 9'h007;

    initial begin
        #1000000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: run hung, actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; chk_bus = '0; src_data = '0; rd_active = 0; gen_en = 0;
        odd_sel = 0; size_sel = 2'b00; big_end = 0;
        for (int i = 0; i < 3; i++) begin h_sz[i] = 2'b00; h_be[i] = 1'b0; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // reset state: long word, all lanes good -> no error (R5, R3)
        step({GE, GE, GE, GE}, 36'h123456789, 0, 0, 0, 2'b00, 0, "R5 reset long word");
        // lane layout and even sense (R1, R2)
        step({GE, GE, BE, GE}, 36'h0, 0, 0, 0, 2'b00, 0, "R1 lane 1 bad even");
        step({BE, GE, GE, GE}, 36'h0, 0, 0, 0, 2'b00, 0, "R1 lane 3 bad even");
        // odd sense flips the verdict (R2)
        step({GE, GE, GE, GE}, 36'h0, 0, 0, 1, 2'b00, 0, "R2 even lanes under odd sense");
        step({BE, BE, BE, BE}, 36'h0, 0, 0, 1, 2'b00, 0, "R2 odd lanes under odd sense");
        // word, big endian: applied now, active after two edges (R5, R4)
        step({GE, GE, GE, BE}, 36'h0, 0, 0, 0, 2'b01, 1, "R5 word change cycle 0");
        step({GE, GE, GE, BE}, 36'h0, 0, 0, 0, 2'b01, 1, "R5 word change cycle 1");
        step({GE, GE, GE, BE}, 36'h0, 0, 0, 0, 2'b01, 1, "R4 word BE ignores lane 0");
        step({GE, BE, GE, GE}, 36'h0, 0, 0, 0, 2'b01, 1, "R4 word BE checks lane 2");
        // word, little endian
        step({BE, GE, GE, GE}, 36'h0, 0, 0, 0, 2'b01, 0, "R5 word LE cycle 0");
        step({BE, GE, GE, GE}, 36'h0, 0, 0, 0, 2'b01, 0, "R5 word LE cycle 1");
        step({BE, BE, GE, GE}, 36'h0, 0, 0, 0, 2'b01, 0, "R4 word LE ignores lanes 3,2");
        step({GE, GE, BE, GE}, 36'h0, 0, 0, 0, 2'b01, 0, "R4 word LE checks lane 1");
        // byte, big endian then little endian
        for (int k = 0; k < 2; k++)
            step({GE, BE, BE, BE}, 36'h0, 0, 0, 0, 2'b10, 1, "R5 byte BE settling");
        step({GE, BE, BE, BE}, 36'h0, 0, 0, 0, 2'b10, 1, "R4 byte BE ignores lanes 2..0");
        step({BE, GE, GE, GE}, 36'h0, 0, 0, 0, 2'b10, 1, "R4 byte BE checks lane 3");
        for (int k = 0; k < 2; k++)
            step({BE, BE, BE, GE}, 36'h0, 0, 0, 0, 2'b10, 0, "R5 byte LE settling");
        step({BE, BE, BE, GE}, 36'h0, 0, 0, 0, 2'b10, 0, "R4 byte LE ignores lanes 3..1");
        step({GE, GE, GE, BE}, 36'h0, 0, 0, 0, 2'b10, 0, "R4 byte LE checks lane 0");
        // register access width checks all lanes
        for (int k = 0; k < 2; k++)
            step({GE, GE, GE, GE}, 36'h0, 0, 0, 0, 2'b11, 0, "R5 reg width settling");
        step({GE, GE, BE, GE}, 36'h0, 0, 0, 0, 2'b11, 0, "R4 reg width checks lane 1");
        // generation with bad inbound lanes: flag forced, parity rebuilt (R6, R8)
        step({BE, BE, BE, BE}, 36'hF0F0F0F0F, 1, 1, 0, 2'b11, 0, "R8 R6 gen even bad inbound");
        step({GE, GE, GE, GE}, 36'hABCDEF012, 1, 1, 1, 2'b11, 0, "R8 R6 gen odd bad inbound");
        step({BE, GE, BE, GE}, 36'hFFFFFFFFF, 1, 1, 0, 2'b00, 0, "R6 gen all ones even");
        step({GE, BE, GE, BE}, 36'h000000000, 1, 1, 1, 2'b00, 0, "R6 gen all zero odd");
        // read without generation and generation without read: passthrough (R7)
        step({GE, GE, GE, BE}, 36'h9A5A5A5A5, 1, 0, 0, 2'b00, 0, "R7 read no gen");
        step({GE, GE, GE, GE}, 36'h812345678, 0, 1, 1, 2'b00, 0, "R7 gen without read");
        step({GE, GE, GE, GE}, 36'h1FF1FF1FF, 0, 0, 0, 2'b00, 0, "R7 idle passthrough");

        repeat (3) @(posedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule